// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Unit

This block watches a group of eight input pins and turns a chosen transition on each one into a latched interrupt flag. For each pin, software picks the edge direction, enables or masks that pin's contribution to the request, and clears flags once it has handled them. A flag records its event even while the pin is masked, so software can poll for activity without taking interrupts. All latched-and-enabled flags are merged into a single request line that goes to the processor's interrupt controller.

Pins can be sampled directly, or through a synchronizer of two or more stages when the pin sources are asynchronous to the clock. A static configuration input picks the path. Edge detection always compares two consecutive samples taken on the selected path. Because the detector tracks raw levels and not the chosen polarity, changing the polarity setting never creates an event by itself. The unit has three byte-wide registers on a simple single-cycle read/write bus.

Top module: `pin_edge_irq`

## Requirements
- R1: Registers sit at BASE (default 0x017) + 0 for polarity, + 1 for flags and + 2 for enables, and bit i of each belongs to pin i. A read with `bus_sel_i` high and `bus_we_i` low returns that register combinationally. Any other address reads 0.
- R2: With polarity bit 0, a low-to-high change on the pin sets its flag, and a high-to-low change does not.
- R3: With polarity bit 1, a high-to-low change on the pin sets its flag, and a low-to-high change does not.
- R4: A flag is set by its selected edge even when its enable bit is 0, and `irq_o` then stays low.
- R5: `irq_o` is high exactly when some pin has both its flag and its enable bit set. Writing an enable bit while its flag is already set raises `irq_o` in the cycle after the write edge. Writing all enables to 0 lowers it in that cycle.
- R6: Flags hold until software writes the flag register. The written value replaces the flags, so a 0 clears a bit and a 1 sets it.
- R7: If a selected edge and a write of 0 to the same flag bit land in the same clock cycle, the flag ends up set.
- R8: Changing polarity bits while the pins are steady sets no flag.
- R9: Reset clears polarity (all rising), flags and enables, and holds `irq_o` low.
- R10: With `cfg_direct_i` = 1, a pin change driven before a clock edge sets the flag at that edge. With `cfg_direct_i` = 0, the change goes through two synchronizer stages and the flag sets two clock edges later.
- R11: A bus cycle with `bus_we_i` high and an unmapped address, or with `bus_sel_i` low, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_direct_i | input | 1 | 1: sample pins directly; 0: through synchronizer (static) |
| pins_i | input | 8 | Pin levels |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (0 when not selected or unmapped) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `cfg_direct_i` only changes while the pins are steady, and that pins hold low through reset, because the first sample after reset compares against a cleared history. They also assume that each bus write lasts exactly one clock edge. The stimulus drives all inputs on falling edges and switches the sampling mode only after the pins have been still for several cycles. It keeps the pins low during reset and clears leftover flags before each table vector, so every vector starts from a known history.

// File: rtl/pei_pkg.sv
package pei_pkg;
   typedef enum logic [1:0] {
      SEL_POL  = 2'd0,
      SEL_FLAG = 2'd1,
      SEL_EN   = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   function automatic logic edge_hit(input logic cur, input logic prev, input logic falling);
      return falling ? (prev & ~cur) : (cur & ~prev);
   endfunction
endpackage

// File: rtl/pei_sampler.sv
module pei_sampler #(
   parameter int NUM_PINS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                direct_i,
   input  logic [NUM_PINS-1:0] pins_i,
   output logic [NUM_PINS-1:0] cur_o,
   output logic [NUM_PINS-1:0] prev_o
);
   localparam int CHAIN_LEN = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("pei_sampler: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] chain_q [CHAIN_LEN];
   logic [NUM_PINS-1:0] raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= pins_i;
   end

   for (genvar s = 1; s < CHAIN_LEN; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= pins_i;
   end

   always_comb begin
      if (direct_i) begin
         cur_o  = pins_i;
         prev_o = raw_q;
      end else begin
         cur_o  = chain_q[SYNC_STAGES-1];
         prev_o = chain_q[SYNC_STAGES];
      end
   end
endmodule

// File: rtl/pei_edge_cell.sv
module pei_edge_cell (
   input  logic cur_i,
   input  logic prev_i,
   input  logic falling_i,
   output logic hit_o
);
   import pei_pkg::*;
   always_comb hit_o = edge_hit(cur_i, prev_i, falling_i);
endmodule

// File: rtl/pei_regs.sv
module pei_regs #(
   parameter int NUM_PINS  = 8,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 9,
   parameter int BASE_ADDR = 'h017
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel_i,
   input  logic                we_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic [NUM_PINS-1:0] evt_i,
   output logic [DATA_W-1:0]   rdata_o,
   output logic [NUM_PINS-1:0] pol_q,
   output logic [NUM_PINS-1:0] flag_q,
   output logic [NUM_PINS-1:0] en_q
);
   import pei_pkg::*;

   localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(BASE_ADDR + 1);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(BASE_ADDR + 2);

   reg_sel_e            sel;
   logic                wr;
   logic [NUM_PINS-1:0] wbits;
   logic [NUM_PINS-1:0] flag_base;

   always_comb begin
      unique case (addr_i)
         A_POL:   sel = SEL_POL;
         A_FLAG:  sel = SEL_FLAG;
         A_EN:    sel = SEL_EN;
         default: sel = SEL_NONE;
      endcase
   end

   assign wr    = sel_i & we_i;
   assign wbits = wdata_i[NUM_PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pol_q <= '0;
      else if (wr && sel == SEL_POL)   pol_q <= wbits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      en_q <= '0;
      else if (wr && sel == SEL_EN)    en_q <= wbits;
   end

   always_comb flag_base = (wr && sel == SEL_FLAG) ? wbits : flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_base | evt_i;
   end

   always_comb begin
      rdata_o = '0;
      if (sel_i && !we_i) begin
         unique case (sel)
            SEL_POL:  rdata_o[NUM_PINS-1:0] = pol_q;
            SEL_FLAG: rdata_o[NUM_PINS-1:0] = flag_q;
            SEL_EN:   rdata_o[NUM_PINS-1:0] = en_q;
            default:  rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
   parameter int NUM_PINS    = 8,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 9,
   parameter int BASE_ADDR   = 'h017,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_direct_i,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic                bus_sel_i,
   input  logic                bus_we_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   output logic                irq_o
);
   if (NUM_PINS > DATA_W || NUM_PINS < 1) begin : g_bad_width
      $error("pin_edge_irq: NUM_PINS must be in 1..DATA_W");
   end
   if (BASE_ADDR + 2 >= (1 << ADDR_W)) begin : g_bad_addr
      $error("pin_edge_irq: register window exceeds address space");
   end

   logic [NUM_PINS-1:0] cur;
   logic [NUM_PINS-1:0] prev;
   logic [NUM_PINS-1:0] evt;
   logic [NUM_PINS-1:0] pol_q;
   logic [NUM_PINS-1:0] flag_q;
   logic [NUM_PINS-1:0] en_q;

   pei_sampler #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_samp (
      .clk(clk), .rst_n(rst_n), .direct_i(cfg_direct_i),
      .pins_i(pins_i), .cur_o(cur), .prev_o(prev)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pei_edge_cell u_cell (
         .cur_i(cur[i]), .prev_i(prev[i]), .falling_i(pol_q[i]), .hit_o(evt[i])
      );
   end

   pei_regs #(
      .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .sel_i(bus_sel_i), .we_i(bus_we_i),
      .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .evt_i(evt),
      .rdata_o(bus_rdata_o), .pol_q(pol_q), .flag_q(flag_q), .en_q(en_q)
   );

   assign irq_o = |(flag_q & en_q);
endmodule

// File: rtl/pin_edge_irq_chk.sv
module pin_edge_irq_chk #(
   parameter int NUM_PINS  = 8,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 9,
   parameter int BASE_ADDR = 'h017
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_sel_i,
   input logic                bus_we_i,
   input logic [ADDR_W-1:0]   bus_addr_i,
   input logic [DATA_W-1:0]   bus_wdata_i,
   input logic                irq_o,
   input logic [NUM_PINS-1:0] flag_q,
   input logic [NUM_PINS-1:0] evt
);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(BASE_ADDR + 1);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(BASE_ADDR + 2);

   logic wr_flag;
   logic clr_en;
   assign wr_flag = bus_sel_i && bus_we_i && (bus_addr_i == A_FLAG);
   assign clr_en  = bus_sel_i && bus_we_i && (bus_addr_i == A_EN) &&
                    (bus_wdata_i[NUM_PINS-1:0] == '0);

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R6
   AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> ((flag_q & ~$past(flag_q) & ~$past(evt)) == '0)); // R2
   AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((flag_q & $past(evt)) == $past(evt))); // R7
   AST_MASK_ALL_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> !irq_o); // R5

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!irq_o && flag_q == '0); // R9
      end
   end
endmodule

bind pin_edge_irq pin_edge_irq_chk #(
   .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
   .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .irq_o(irq_o),
   .flag_q(flag_q), .evt(evt)
);

// File: tb/pin_edge_irq_test.sv
module pin_edge_irq_test;
   localparam logic [8:0] A_POL  = 9'h017;
   localparam logic [8:0] A_FLAG = 9'h018;
   localparam logic [8:0] A_EN   = 9'h019;
   localparam int NVEC = 8;
   // each entry: polarity, level before, level after, expected flags
   localparam logic [31:0] VEC [NVEC] = '{
      {8'h00, 8'h00, 8'hFF, 8'hFF},
      {8'h00, 8'hFF, 8'h00, 8'h00},
      {8'hFF, 8'hFF, 8'h00, 8'hFF},
      {8'hFF, 8'h00, 8'hFF, 8'h00},
      {8'h0F, 8'h00, 8'hFF, 8'hF0},
      {8'h0F, 8'hFF, 8'h00, 8'h0F},
      {8'h00, 8'h5A, 8'hA5, 8'hA5},
      {8'hAA, 8'h5A, 8'hA5, 8'h0F}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_direct = 1'b1;
   logic [7:0] pins = 8'h00;
   logic       sel = 1'b0;
   logic       we = 1'b0;
   logic [8:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pin_edge_irq uut (
      .clk(clk), .rst_n(rst_n), .cfg_direct_i(cfg_direct), .pins_i(pins),
      .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .irq_o(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; we = 1'b0; addr = a;
      #1 d = rdata;
      sel = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      rd(A_POL, v);  check("R9 pol", v, 8'h00);
      rd(A_FLAG, v); check("R9 flag", v, 8'h00);
      rd(A_EN, v);   check("R9 en", v, 8'h00);
      check("R9 irq", {7'b0, irq}, 8'h00);
      // R1 unmapped read
      rd(9'h020, v); check("R1 unmapped", v, 8'h00);

      // R2 R3 table of vectors, direct sampling
      for (int k = 0; k < NVEC; k++) begin
         wr(A_POL, VEC[k][31:24]);
         @(negedge clk); pins = VEC[k][23:16];
         repeat (2) @(negedge clk);
         wr(A_FLAG, 8'h00);
         pins = VEC[k][15:8];
         rd(A_FLAG, v);
         check(VEC[k][31:24] == 8'h00 ? "R2 rising vector" : "R3 polarity vector", v, VEC[k][7:0]);
      end

      // R4 flag without enable, irq low
      wr(A_POL, 8'h00); pins = 8'h00;
      repeat (2) @(negedge clk);
      wr(A_FLAG, 8'h00); wr(A_EN, 8'h00);
      pins = 8'h01;
      rd(A_FLAG, v); check("R4 flag while masked", v, 8'h01);
      check("R4 irq stays low", {7'b0, irq}, 8'h00);
      // R5 enable with pending flag
      wr(A_EN, 8'h01);
      check("R5 irq after enable", {7'b0, irq}, 8'h01);
      wr(A_EN, 8'h00);
      check("R5 irq after mask", {7'b0, irq}, 8'h00);
      wr(A_EN, 8'h01);
      // R6 clear and set by write
      wr(A_FLAG, 8'h00);
      rd(A_FLAG, v); check("R6 clear", v, 8'h00);
      check("R6 irq after clear", {7'b0, irq}, 8'h00);
      wr(A_FLAG, 8'h80);
      rd(A_FLAG, v); check("R6 set by write", v, 8'h80);
      repeat (3) @(negedge clk);
      rd(A_FLAG, v); check("R6 sticky", v, 8'h80);

      // R7 edge meets clearing write
      pins = 8'h00;
      repeat (2) @(negedge clk);
      wr(A_FLAG, 8'h06);
      @(negedge clk);
      sel = 1'b1; we = 1'b1; addr = A_FLAG; wdata = 8'h00; pins = 8'h02;
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
      rd(A_FLAG, v); check("R7 edge wins", v, 8'h02);

      // R8 polarity flips with steady pins
      pins = 8'h04;
      repeat (2) @(negedge clk);
      wr(A_FLAG, 8'h00);
      wr(A_POL, 8'hFF); wr(A_POL, 8'h00); wr(A_POL, 8'h04);
      repeat (2) @(negedge clk);
      rd(A_FLAG, v); check("R8 no false event", v, 8'h00);

      // R11 ignored writes
      wr(A_POL, 8'h00);
      wr(9'h01A, 8'hFF);
      @(negedge clk); sel = 1'b0; we = 1'b1; addr = A_EN; wdata = 8'hFF;
      @(negedge clk); we = 1'b0;
      rd(A_EN, v);  check("R11 en untouched", v, 8'h01);
      rd(A_POL, v); check("R11 pol untouched", v, 8'h00);
      rd(A_FLAG, v); check("R11 flag untouched", v, 8'h00);

      // R10 synchronized path delay
      cfg_direct = 1'b0;
      repeat (5) @(negedge clk);
      wr(A_FLAG, 8'h00);
      pins = 8'h0C;
      rd(A_FLAG, v); check("R10 sync +1", v, 8'h00);
      rd(A_FLAG, v); check("R10 sync +2", v, 8'h00);
      rd(A_FLAG, v); check("R10 sync +3", v, 8'h08);
      cfg_direct = 1'b1;
      repeat (3) @(negedge clk);
      wr(A_FLAG, 8'h00);
      pins = 8'h1C;
      rd(A_FLAG, v); check("R10 direct +1", v, 8'h10);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule